// File: doc/BRIEF.md
# Half-Step Pixel Rate Divider

This block takes a fast display clock and produces a one-cycle pixel strobe. The division ratio is set by an 8-bit code in 7.1 fixed point with an offset of two. The ratio is (code + 2) / 2, so the ratio can step in halves: code 0 is a ratio of 1, code 1 is 1.5, code 2 is 2, and code 255 is 128.5.

Integer ratios give a strobe with a constant period. For a half-integer ratio the block alternates a short period (the floor of the ratio) and a long period (the ceiling). Over each pair of periods the average rate is exactly the input rate divided by the ratio.

A new code is taken only where one period ends and the next begins, so a period is never cut short. While the enable is low, the strobe is held low and the period state is cleared. A package function gives the nearest code for an input frequency and a target pixel frequency; for example, a 600 MHz display clock and a 25 MHz pixel rate give code 46.

Top module: `halfstep_pixdiv`

## Requirements
- R1: With code c and c+2 even, every strobe period lasts exactly (c+2)/2 clock cycles (for example, code 10 gives 6 cycles and code 254 gives 128 cycles).
- R2: Code 0 selects a ratio of 1, so the strobe is high on every enabled cycle.
- R3: With c+2 odd, the periods alternate between floor((c+2)/2) and ceiling((c+2)/2) cycles, and the first period after enable is the shorter one (code 1 gives 1,2,1,2; code 5 gives 3,4; code 255 gives 128,129).
- R4: When the period is longer than one cycle, the strobe is high for exactly one clock cycle per period.
- R5: A code change takes effect only at the next strobe. The period in progress completes with the old length, and the following period uses the new length.
- R6: While enable is low the strobe stays low and the cycle count and half-step phase are cleared. After enable rises, the first strobe comes exactly floor((c+2)/2) clock cycles later.
- R7: While reset is asserted the strobe is low.
- R8: The code helper returns round(2 * f_in / f_pix) - 2, rounded to the nearest integer and clamped to the range 0..255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast display clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enable | input | 1 | Run control; low holds the strobe low and clears the period state |
| div_code | input | 8 | Divider code in 7.1 format; ratio = (div_code + 2) / 2 |
| pix_stb | output | 1 | One-cycle pixel-rate strobe |

## Verification
The divider is driven with several codes, each of which separates a different fault:
- Code 0 separates a true bypass from an off-by-one period.
- Even codes 10 and 254 show that the period length is constant and has no error in the half bit.
- Odd codes 1, 5 and 255 show the floor/ceiling alternation, which phase comes first, and the widest counts.

A code change in the middle of a period shows whether the code is latched only at the strobe. Disabling in the middle of a period and then re-enabling shows that both the count and the half-step phase are cleared. The helper function is checked at frequency pairs that round down, round up, and clamp at both ends.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

  localparam int unsigned CODE_W = 8;

  // Nearest divider code for a given input and pixel frequency (7.1, offset 2)
  function automatic logic [CODE_W-1:0] pcd_code_for(input longint unsigned f_in,
                                                     input longint unsigned f_pix);
    longint signed twice_ratio;
    longint signed code_l;
    longint signed max_code;
    max_code    = (longint'(1) <<< CODE_W) - 1;
    twice_ratio = longint'((2 * f_in + f_pix / 2) / f_pix);
    code_l      = twice_ratio - 2;
    if (code_l < 0) code_l = 0;
    if (code_l > max_code) code_l = max_code;
    return code_l[CODE_W-1:0];
  endfunction

endpackage

// File: rtl/pcd_len_calc.sv
// Period length in clock cycles for the given code and half-step phase.
module pcd_len_calc #(
  parameter int unsigned CODE_W = 8,
  localparam int unsigned SUM_W = CODE_W + 1
) (
  input  logic [CODE_W-1:0] code,
  input  logic              phase,
  output logic [CODE_W-1:0] len
);
  logic [SUM_W-1:0] half_units;

  always_comb begin
    half_units = {1'b0, code} + SUM_W'(2) + SUM_W'(phase);
    len        = half_units[SUM_W-1:1];
  end
endmodule

// File: rtl/pcd_period_counter.sv
// Counts the cycles of one period and flags its last cycle.
module pcd_period_counter #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [LEN_W-1:0] len,
  output logic             last_cyc
);
  logic [LEN_W-1:0] cnt_q, cnt_n;

  always_comb begin
    last_cyc = enable && (cnt_q == len - LEN_W'(1));
    if (!enable || last_cyc) cnt_n = '0;
    else                     cnt_n = cnt_q + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R6
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt_q == '0));

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> (cnt_q < len));
endmodule

// File: rtl/halfstep_pixdiv.sv
module halfstep_pixdiv #(
  parameter int unsigned CODE_W = pcd_pkg::CODE_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CODE_W-1:0] div_code,
  output logic              pix_stb
);
  // Reset: asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[SYNC_STAGES-1];

  logic [CODE_W-1:0] len_q, len_n, len_calc;
  logic              phase_q, phase_n, phase_sel;
  logic              stb_q, stb_n;
  logic              last_cyc;
  logic              len_load;

  pcd_len_calc #(.CODE_W(CODE_W)) u_len (
    .code  (div_code),
    .phase (phase_sel),
    .len   (len_calc)
  );

  pcd_period_counter #(.LEN_W(CODE_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .enable   (enable),
    .len      (len_q),
    .last_cyc (last_cyc)
  );

  // Next-state logic
  always_comb begin
    phase_sel = enable ? (div_code[0] ? ~phase_q : 1'b0) : 1'b0;
    len_load  = !enable || last_cyc;
    phase_n   = len_load ? phase_sel : phase_q;
    len_n     = len_load ? len_calc  : len_q;
    stb_n     = last_cyc;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      len_q   <= CODE_W'(1);
      phase_q <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      len_q   <= len_n;
      phase_q <= phase_n;
      stb_q   <= stb_n;
    end
  end

  assign pix_stb = stb_q;

  // R6
  strobe_off_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !enable |=> !pix_stb);

  // R5
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (enable && !last_cyc) |=> $stable(len_q));

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pix_stb && len_q > CODE_W'(1)) |=> !pix_stb);

  // R3
  phase_zero_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !enable |=> !phase_q);
endmodule

// File: tb/halfstep_pixdiv_bench.sv
module halfstep_pixdiv_bench;
  import pcd_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic [7:0] div_code;
  logic       pix_stb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  halfstep_pixdiv u_halfstep_pixdiv (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .div_code (div_code),
    .pix_stb  (pix_stb)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(input logic [7:0] c);
    @(negedge clk);
    enable   = 1'b0;
    div_code = c;
    @(negedge clk);
    @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic next_gap(output int g);
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!pix_stb && g < 1000);
  endtask

  task automatic t_reset;
    int highs;
    highs    = 0;
    rst_n    = 1'b0;
    enable   = 1'b1;
    div_code = 8'd0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (pix_stb) highs++;
    end
    chk("R7 strobe high during reset", highs, 0);
    rst_n = 1'b1;
    enable = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_bypass;
    int g;
    start(8'd0);
    for (int i = 0; i < 4; i++) begin
      next_gap(g);
      chk("R2 code0 period", g, 1);
    end
  endtask

  task automatic t_even(input logic [7:0] c, input int n);
    int g;
    start(c);
    for (int i = 0; i < n; i++) begin
      next_gap(g);
      chk("R1 even period / R4 one-cycle pulse", g, (int'(c) + 2) / 2);
    end
  endtask

  task automatic t_odd(input logic [7:0] c, input int n);
    int g;
    start(c);
    for (int i = 0; i < n; i++) begin
      next_gap(g);
      chk("R3 odd alternation", g, (int'(c) + 2 + (i % 2)) / 2);
    end
  endtask

  task automatic t_change;
    int g;
    start(8'd10);
    next_gap(g);
    chk("R5 first period", g, 6);
    @(negedge clk);
    @(negedge clk);
    div_code = 8'd2;
    next_gap(g);
    g += 2;
    chk("R5 period in progress keeps old length", g, 6);
    next_gap(g);
    chk("R5 new length after boundary", g, 2);
  endtask

  task automatic t_disable;
    int g;
    int highs;
    start(8'd5);
    next_gap(g);
    chk("R6 pre-disable period", g, 3);
    @(negedge clk);
    enable = 1'b0;
    highs  = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (pix_stb) highs++;
    end
    chk("R6 strobe while disabled", highs, 0);
    enable = 1'b1;
    next_gap(g);
    chk("R6 first period after re-enable", g, 3);
    next_gap(g);
    chk("R6 second period after re-enable", g, 4);
  endtask

  task automatic t_helper;
    chk("R8 600M/25M", int'(pcd_code_for(64'd600_000_000, 64'd25_000_000)), 46);
    chk("R8 600M/40M", int'(pcd_code_for(64'd600_000_000, 64'd40_000_000)), 28);
    chk("R8 600M/70M", int'(pcd_code_for(64'd600_000_000, 64'd70_000_000)), 15);
    chk("R8 equal rates", int'(pcd_code_for(64'd600_000_000, 64'd600_000_000)), 0);
    chk("R8 clamp low", int'(pcd_code_for(64'd100, 64'd1000)), 0);
    chk("R8 clamp high", int'(pcd_code_for(64'd600_000_000, 64'd1_000_000)), 255);
  endtask

  initial begin
    enable   = 1'b0;
    div_code = 8'd0;
    rst_n    = 1'b0;
    t_reset();
    t_bypass();
    t_even(8'd10, 4);
    t_even(8'd254, 2);
    t_odd(8'd1, 4);
    t_odd(8'd5, 4);
    t_odd(8'd255, 2);
    t_change();
    t_disable();
    t_helper();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule